// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block walks a run of equal-sized elements in memory, one element per iteration, on behalf of a string-style instruction. A single `start` pulse hands it two address registers (source and destination), an element count, a direction bit, an element size, an accumulator value, an operation selector and a repeat mode. It then issues reads and writes on a single memory request port, moves the addresses by the element width, decrements the count, and decides after every element whether to keep going.

Five operations exist: copy (source to destination), store (accumulator to destination), load (source into accumulator), compare (source element against destination element) and scan (accumulator against destination element). Compare and scan set a zero flag and, under the two conditional repeat modes, can end the run before the count is used up. When the run ends, `done` pulses for one cycle and the final addresses, count, accumulator and zero flag stay on the outputs until the next start.

The memory port is valid/ready with one outstanding request. A request (address, size, write enable, write data) is held unchanged while `mem_req_valid` is high and `mem_req_ready` is low, and it is accepted on the cycle both are high. Writes finish on acceptance. A read is answered later by a one-cycle `mem_rsp_valid` with the element in the low bytes of `mem_rsp_data`; the response side has no back-pressure, and the block issues no new request while a read is outstanding. Memory is byte addressed, little-endian.

Top module: `strseq_top`

## Requirements
- R1: After each element, the address registers used by the operation move by the element width (size code 0,1,2,3 gives 1,2,4,8 bytes): up when the direction bit is 0, down when it is 1, wrapping modulo the address width. Copy and compare move both, load moves only the source, store and scan only the destination.
- R2: Copy (operation code 0) reads the element at the source address and writes it to the destination address; bytes outside the element are not touched.
- R3: Store (code 1) writes the low element bytes of the accumulator to the destination; load (code 2) reads the source element into the low bytes of the accumulator and keeps its upper bytes.
- R4: Compare (code 3) reads the source then the destination element and sets the zero flag to 1 when they are equal; scan (code 4) reads the destination element and sets the zero flag when it equals the low element bytes of the accumulator. Neither writes memory.
- R5: Repeat mode codes are 0 none, 1 unconditional, 2 while-equal, 3 while-not-equal. In modes 1 to 3 each element decrements the count and the run ends when the count reaches zero.
- R6: In mode 2 a compare or scan run ends after an element that leaves the zero flag at 0; in mode 3 after one that leaves it at 1. For copy, store and load, modes 2 and 3 behave as mode 1.
- R7: In mode 0 exactly one element is processed whatever the count, and the count is returned unchanged.
- R8: In modes 1 to 3 with a zero count, no memory request is made, `done` is high in the cycle after the start cycle, and addresses, count, accumulator and zero flag are unchanged.
- R9: A request is held stable until accepted, at most one read is outstanding, and each element costs exactly its accesses: copy and compare two, store, load and scan one.
- R10: `busy` is high from the cycle after an accepted start until `done`; `done` is a single-cycle pulse; after reset the block is idle with zero flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the cfg_* values (taken only when idle) |
| cfg_op | input | 3 | Operation: 0 copy, 1 store, 2 load, 3 compare, 4 scan |
| cfg_rep | input | 2 | Repeat mode: 0 none, 1 unconditional, 2 while-equal, 3 while-not-equal |
| cfg_dir | input | 1 | 0 addresses go up, 1 addresses go down |
| cfg_size | input | 2 | Element size code: 1 << code bytes |
| cfg_src | input | AW | Starting source address |
| cfg_dst | input | AW | Starting destination address |
| cfg_cnt | input | CW | Element count |
| cfg_acc | input | DW | Starting accumulator |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_out | output | AW | Current/final source address |
| dst_out | output | AW | Current/final destination address |
| cnt_out | output | CW | Current/final count |
| acc_out | output | DW | Current/final accumulator |
| zf_out | output | 1 | Zero flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Byte address of the element |
| mem_req_size | output | 2 | Element size code |
| mem_req_wdata | output | DW | Write element, low bytes |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | DW | Read element, low bytes |

## Verification
The bench builds the block with a 10-bit address, 64-bit data and an 8-bit count, so a 1 KiB byte array mirrors the whole address space and a downward run from address 1 crosses the wrap to the top of memory. The 64-bit data width lets every element size, including 8-byte elements, be copied and compared. The memory model stalls `mem_req_ready` and delays read responses on a pseudo-random pattern, which exercises the held-request and single-outstanding-read rules on every element.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

  typedef enum logic [2:0] {
    OP_COPY  = 3'd0,
    OP_STORE = 3'd1,
    OP_LOAD  = 3'd2,
    OP_CMP   = 3'd3,
    OP_SCAN  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_ALL  = 2'd1,
    RP_EQ   = 2'd2,
    RP_NE   = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_WT_SRC,
    ST_RD_DST,
    ST_WT_DST,
    ST_WR,
    ST_EVAL,
    ST_DONE
  } st_e;

  // first memory step of an element
  function automatic st_e first_step(op_e op);
    case (op)
      OP_STORE: first_step = ST_WR;
      OP_SCAN:  first_step = ST_RD_DST;
      OP_COPY, OP_LOAD, OP_CMP: first_step = ST_RD_SRC;
      default:  first_step = ST_EVAL;
    endcase
  endfunction

  function automatic logic moves_src(op_e op);
    moves_src = (op == OP_COPY) || (op == OP_LOAD) || (op == OP_CMP);
  endfunction

  function automatic logic moves_dst(op_e op);
    moves_dst = (op == OP_COPY) || (op == OP_STORE) || (op == OP_CMP) || (op == OP_SCAN);
  endfunction

  function automatic logic sets_flag(op_e op);
    sets_flag = (op == OP_CMP) || (op == OP_SCAN);
  endfunction

endpackage

// File: rtl/strseq_addr_step.sv
module strseq_addr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          dir,
  input  logic [1:0]    size,
  input  logic          en,
  output logic [AW-1:0] next
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] stride;
  assign stride = ONE << size;

  always_comb begin
    if (!en)      next = addr;
    else if (dir) next = addr - stride;
    else          next = addr + stride;
  end
endmodule

// File: rtl/strseq_lane_cmp.sv
module strseq_lane_cmp #(
  parameter int DW = 64
) (
  input  logic [1:0]    size,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] mask,
  output logic          equal
);
  localparam int LANES = DW / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g*8 +: 8] = {8{(32'(g) < (32'd1 << size))}};
  end

  assign equal = (((lhs ^ rhs) & mask) == '0);
endmodule

// File: rtl/strseq_stop.sv
module strseq_stop (
  input  logic [1:0] rep,
  input  logic       flag_op,
  input  logic       zf_new,
  input  logic       cnt_zero,
  output logic       stop
);
  import strseq_pkg::*;

  always_comb begin
    case (rep_e'(rep))
      RP_NONE: stop = 1'b1;
      RP_EQ:   stop = cnt_zero || (flag_op && !zf_new);
      RP_NE:   stop = cnt_zero || (flag_op && zf_new);
      default: stop = cnt_zero;
    endcase
  end
endmodule

// File: rtl/strseq_top.sv
module strseq_top #(
  parameter int AW = 16,
  parameter int DW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cfg_op,
  input  logic [1:0]    cfg_rep,
  input  logic          cfg_dir,
  input  logic [1:0]    cfg_size,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [DW-1:0] cfg_acc,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [CW-1:0] cnt_out,
  output logic [DW-1:0] acc_out,
  output logic          zf_out,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [1:0]    mem_req_size,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  import strseq_pkg::*;

  localparam int NPTR = 2;  // 0: source, 1: destination

  st_e           state;
  op_e           op_q;
  rep_e          rep_q;
  logic          dir_q;
  logic [1:0]    size_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] acc_q, a_q, b_q;
  logic          zf_q;

  // element lane mask and flag evaluation
  logic [DW-1:0] mask;
  logic          eq;
  logic [DW-1:0] cmp_lhs;
  assign cmp_lhs = (op_q == OP_SCAN) ? acc_q : a_q;

  strseq_lane_cmp #(.DW(DW)) u_cmp (
    .size  (size_q),
    .lhs   (cmp_lhs),
    .rhs   (b_q),
    .mask  (mask),
    .equal (eq)
  );

  // address steppers, one per pointer
  logic [AW-1:0] ptr_cur [NPTR];
  logic [AW-1:0] ptr_nxt [NPTR];
  logic          ptr_en  [NPTR];
  assign ptr_cur[0] = src_q;
  assign ptr_cur[1] = dst_q;
  assign ptr_en[0]  = moves_src(op_q);
  assign ptr_en[1]  = moves_dst(op_q);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    strseq_addr_step #(.AW(AW)) u_step (
      .addr (ptr_cur[g]),
      .dir  (dir_q),
      .size (size_q),
      .en   (ptr_en[g]),
      .next (ptr_nxt[g])
    );
  end

  // count and stop decision
  logic [CW-1:0] cnt_nxt;
  logic          zf_nxt;
  logic          stop;
  assign cnt_nxt = (rep_q == RP_NONE) ? cnt_q : cnt_q - {{(CW-1){1'b0}}, 1'b1};
  assign zf_nxt  = sets_flag(op_q) ? eq : zf_q;

  strseq_stop u_stop (
    .rep      (rep_q),
    .flag_op  (sets_flag(op_q)),
    .zf_new   (zf_nxt),
    .cnt_zero (cnt_nxt == '0),
    .stop     (stop)
  );

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_COPY;
      rep_q  <= RP_NONE;
      dir_q  <= 1'b0;
      size_q <= 2'd0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      zf_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          op_q   <= op_e'(cfg_op);
          rep_q  <= rep_e'(cfg_rep);
          dir_q  <= cfg_dir;
          size_q <= cfg_size;
          src_q  <= cfg_src;
          dst_q  <= cfg_dst;
          cnt_q  <= cfg_cnt;
          acc_q  <= cfg_acc;
          if ((rep_e'(cfg_rep) != RP_NONE) && (cfg_cnt == '0)) state <= ST_DONE;
          else state <= first_step(op_e'(cfg_op));
        end
        ST_RD_SRC: if (mem_req_ready) state <= ST_WT_SRC;
        ST_WT_SRC: if (mem_rsp_valid) begin
          a_q <= mem_rsp_data & mask;
          case (op_q)
            OP_COPY: state <= ST_WR;
            OP_CMP:  state <= ST_RD_DST;
            default: state <= ST_EVAL;
          endcase
        end
        ST_RD_DST: if (mem_req_ready) state <= ST_WT_DST;
        ST_WT_DST: if (mem_rsp_valid) begin
          b_q   <= mem_rsp_data & mask;
          state <= ST_EVAL;
        end
        ST_WR: if (mem_req_ready) state <= ST_EVAL;
        ST_EVAL: begin
          src_q <= ptr_nxt[0];
          dst_q <= ptr_nxt[1];
          cnt_q <= cnt_nxt;
          zf_q  <= zf_nxt;
          if (op_q == OP_LOAD) acc_q <= (acc_q & ~mask) | a_q;
          state <= stop ? ST_DONE : first_step(op_q);
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // memory request
  assign mem_req_valid = (state == ST_RD_SRC) || (state == ST_RD_DST) || (state == ST_WR);
  assign mem_req_we    = (state == ST_WR);
  assign mem_req_addr  = (state == ST_RD_SRC) ? src_q : dst_q;
  assign mem_req_size  = size_q;
  assign mem_req_wdata = ((op_q == OP_COPY) ? a_q : acc_q) & mask;

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign src_out = src_q;
  assign dst_out = dst_q;
  assign cnt_out = cnt_q;
  assign acc_out = acc_q;
  assign zf_out  = zf_q;
endmodule

// File: rtl/strseq_chk.sv
module strseq_chk #(
  parameter int AW = 16,
  parameter int DW = 64,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [2:0]    cfg_op,
  input logic [1:0]    cfg_rep,
  input logic [CW-1:0] cfg_cnt,
  input logic [CW-1:0] cnt_out,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid
);
  logic          rd_open;
  logic [CW-1:0] cnt_cap;
  logic [1:0]    rep_cap;
  logic          flag_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_open  <= 1'b0;
      cnt_cap  <= '0;
      rep_cap  <= 2'd0;
      flag_cap <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_we) rd_open <= 1'b1;
      else if (mem_rsp_valid) rd_open <= 1'b0;
      if (start && !busy) begin
        cnt_cap  <= cfg_cnt;
        rep_cap  <= cfg_rep;
        flag_cap <= (cfg_op == 3'd3) || (cfg_op == 3'd4);
      end
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R9
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_req_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (cfg_rep != 2'd0) && (cfg_cnt == '0) |=> done && !mem_req_valid);

  // R7
  single_keep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (rep_cap == 2'd0) |-> cnt_out == cnt_cap);

  // R4
  flag_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && flag_cap |-> !(mem_req_valid && mem_req_we));
endmodule

bind strseq_top strseq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .cfg_op        (cfg_op),
  .cfg_rep       (cfg_rep),
  .cfg_cnt       (cfg_cnt),
  .cnt_out       (cnt_out),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_strseq_top.sv
module tb_strseq_top;
  localparam int AW = 10;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int MEMB = 1 << AW;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    cfg_op = '0;
  logic [1:0]    cfg_rep = '0;
  logic          cfg_dir = 1'b0;
  logic [1:0]    cfg_size = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic [DW-1:0] cfg_acc = '0;
  logic          busy, done, zf_out;
  logic [AW-1:0] src_out, dst_out;
  logic [CW-1:0] cnt_out;
  logic [DW-1:0] acc_out;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [1:0]    mem_req_size;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  strseq_top #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

  // ---------------- memory model ----------------
  logic [7:0]    mem [MEMB];
  logic [7:0]    lfsr;
  logic          rd_pend;
  logic [AW-1:0] rd_a;
  logic [1:0]    rd_s, dly;
  int            nreq;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_data = '0;

  function automatic logic [7:0] pattern(int i);
    return 8'(i * 7 + 3) ^ 8'((i >> 8) * 8'h35);
  endfunction

  assign mem_req_ready = !rd_pend && (lfsr[0] || lfsr[2]);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      lfsr    <= 8'h5B;
      rd_pend <= 1'b0;
      nreq    <= 0;
      for (int i = 0; i < MEMB; i++) mem[i] <= pattern(i);
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (host_we) mem[host_addr] <= host_data;
      if (mem_req_valid && mem_req_ready) begin
        nreq <= nreq + 1;
        if (mem_req_we) begin
          for (int k = 0; k < 8; k++)
            if (k < (1 << mem_req_size)) mem[mem_req_addr + AW'(k)] <= mem_req_wdata[8*k +: 8];
        end else begin
          rd_pend <= 1'b1;
          rd_a    <= mem_req_addr;
          rd_s    <= mem_req_size;
          dly     <= lfsr[2:1];
        end
      end else if (rd_pend) begin
        if (dly == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          rd_pend       <= 1'b0;
          for (int k = 0; k < 8; k++)
            mem_rsp_data[8*k +: 8] <= (k < (1 << rd_s)) ? mem[rd_a + AW'(k)] : 8'hEE;
        end else dly <= dly - 2'd1;
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  logic [7:0]    exp_mem [MEMB];
  logic [AW-1:0] e_src, e_dst;
  logic [CW-1:0] e_cnt;
  logic [63:0]   e_acc;
  logic          e_zf;
  int            e_elems, e_reqs;

  function automatic logic [63:0] rd_exp(logic [AW-1:0] a, int nb);
    logic [63:0] v = '0;
    for (int k = 0; k < nb; k++) v[8*k +: 8] = exp_mem[a + AW'(k)];
    return v;
  endfunction

  task automatic ref_run(int op, int rep, int dir, int sz, logic [AW-1:0] s, logic [AW-1:0] d,
                         logic [CW-1:0] c, logic [63:0] acc, logic zf);
    int nb = 1 << sz;
    logic [63:0] m = (sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nb)) - 64'd1);
    logic [63:0] ea, eb;
    bit go = !(rep != 0 && c == 0);
    e_elems = 0;
    e_reqs  = 0;
    while (go) begin
      ea = rd_exp(s, nb);
      eb = rd_exp(d, nb);
      case (op)
        0: begin for (int k = 0; k < nb; k++) exp_mem[d + AW'(k)] = ea[8*k +: 8]; e_reqs += 2; end
        1: begin for (int k = 0; k < nb; k++) exp_mem[d + AW'(k)] = acc[8*k +: 8]; e_reqs += 1; end
        2: begin acc = (acc & ~m) | ea; e_reqs += 1; end
        3: begin zf = (ea == eb); e_reqs += 2; end
        default: begin zf = ((acc & m) == eb); e_reqs += 1; end
      endcase
      if (op == 0 || op == 2 || op == 3) s = dir ? s - AW'(nb) : s + AW'(nb);
      if (op != 2) d = dir ? d - AW'(nb) : d + AW'(nb);
      if (rep != 0) c = c - 1'b1;
      e_elems++;
      if (rep == 0 || c == 0) go = 0;
      else if (op >= 3 && rep == 2 && !zf) go = 0;
      else if (op >= 3 && rep == 3 && zf) go = 0;
    end
    e_src = s; e_dst = d; e_cnt = c; e_acc = acc; e_zf = zf;
  endtask

  task automatic poke(logic [AW-1:0] a, logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  int last_cyc;

  task automatic run(int op, int rep, int dir, int sz, logic [AW-1:0] s, logic [AW-1:0] d,
                     logic [CW-1:0] c, logic [63:0] acc, string cnt_tag, string mem_tag);
    int cyc, r0, bad;
    @(negedge clk);
    for (int i = 0; i < MEMB; i++) exp_mem[i] = mem[i];
    ref_run(op, rep, dir, sz, s, d, c, acc, zf_out);
    r0 = nreq;
    cfg_op = 3'(op); cfg_rep = 2'(rep); cfg_dir = dir[0]; cfg_size = 2'(sz);
    cfg_src = s; cfg_dst = d; cfg_cnt = c; cfg_acc = acc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk("R10", "busy after start", busy, 1);
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!done) chk("R10", "done reached", 0, 1);
    last_cyc = cyc;
    @(negedge clk);
    chk("R10", "done single pulse", done, 0);
    chk("R10", "idle after done", busy, 0);
    chk("R1", "final source address", src_out, e_src);
    chk("R1", "final destination address", dst_out, e_dst);
    chk(cnt_tag, "final count", cnt_out, e_cnt);
    chk("R3", "final accumulator", acc_out, e_acc);
    chk("R4", "zero flag", zf_out, e_zf);
    chk("R9", "memory accesses", nreq - r0, e_reqs);
    bad = 0;
    for (int i = 0; i < MEMB; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(mem_tag, "memory bytes differing", bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset request", mem_req_valid, 0);
    chk("R10", "reset zero flag", zf_out, 0);
  endtask

  task automatic t_copy_fwd_byte();
    run(0, 1, 0, 0, 10'h010, 10'h100, 8'd5, 64'h0, "R5", "R2");
    chk("R1", "copy byte up source", src_out, 10'h015);
    chk("R2", "copied byte", mem[10'h102], pattern(10'h012));
  endtask

  task automatic t_copy_back_quad();
    run(0, 1, 1, 3, 10'h200, 10'h300, 8'd3, 64'h0, "R5", "R2");
    chk("R1", "copy quad down source", src_out, 10'h1E8);
    chk("R2", "copied quad top byte", mem[10'h2F7], pattern(10'h1F7));
  endtask

  task automatic t_store_wrap();
    run(1, 1, 1, 0, 10'h000, 10'h001, 8'd3, 64'h1234_5678_9ABC_DEA5, "R5", "R3");
    chk("R1", "store wraps below zero", dst_out, 10'h3FE);
    chk("R3", "stored byte at top of memory", mem[10'h3FF], 8'hA5);
  endtask

  task automatic t_store_word();
    run(1, 1, 0, 1, 10'h000, 10'h080, 8'd4, 64'hFFFF_FFFF_FFFF_1234, "R5", "R3");
    chk("R1", "store word up destination", dst_out, 10'h088);
    chk("R3", "stored word high byte", mem[10'h087], 8'h12);
    chk("R3", "byte past run untouched", mem[10'h088], pattern(10'h088));
  endtask

  task automatic t_load_single();
    run(2, 0, 0, 2, 10'h040, 10'h000, 8'd7, 64'hFFFF_FFFF_0000_0000, "R7", "R3");
    chk("R7", "no-repeat keeps count", cnt_out, 8'd7);
    chk("R3", "load keeps upper accumulator", acc_out[63:32], 32'hFFFF_FFFF);
    chk("R1", "load moves source only", src_out, 10'h044);
  endtask

  task automatic t_cmp_while_equal();
    for (int k = 0; k < 4; k++) poke(10'h240 + AW'(k), mem[10'h140 + AW'(k)]);
    run(3, 2, 0, 1, 10'h140, 10'h240, 8'd6, 64'h0, "R6", "R4");
    chk("R6", "compare stops at first mismatch", cnt_out, 8'd3);
    chk("R6", "mismatch clears flag", zf_out, 0);
    chk("R1", "compare source after three", src_out, 10'h146);
  endtask

  task automatic t_scan_while_ne();
    poke(10'h183, 8'h5A);
    run(4, 3, 0, 0, 10'h000, 10'h180, 8'd10, 64'h0000_0000_0000_005A, "R6", "R4");
    chk("R6", "scan stops on match", cnt_out, 8'd6);
    chk("R6", "match sets flag", zf_out, 1);
    chk("R1", "scan destination past match", dst_out, 10'h184);
  endtask

  task automatic t_zero_count();
    run(0, 1, 0, 0, 10'h020, 10'h030, 8'd0, 64'h77, "R8", "R8");
    chk("R8", "done one cycle after start", last_cyc, 1);
    chk("R8", "source unchanged", src_out, 10'h020);
    chk("R8", "flag kept from previous run", zf_out, 1);
  endtask

  task automatic t_cond_on_copy();
    run(0, 3, 0, 2, 10'h050, 10'h360, 8'd4, 64'h0, "R6", "R2");
    chk("R6", "copy ignores flag condition", cnt_out, 8'd0);
    chk("R6", "copy moved four dwords", dst_out, 10'h370);
  endtask

  task automatic t_scan_all();
    run(4, 1, 1, 0, 10'h000, 10'h0C2, 8'd3, 64'h0000_0000_0000_0000, "R5", "R4");
    chk("R5", "unconditional scan runs out", cnt_out, 8'd0);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_fwd_byte();
    t_copy_back_quad();
    t_store_wrap();
    t_store_word();
    t_load_single();
    t_cmp_while_equal();
    t_scan_while_ne();
    t_zero_count();
    t_cond_on_copy();
    t_scan_all();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule